// File: doc/BRIEF.md
# Core Memory Word Buffer with Split Parity

This block holds one 16-bit core memory word during a single memory cycle. A cycle opens with a destructive read, in which the storage array sends back a pulse for every bit that held a one. The block gathers those pulses into its buffer register, checks odd parity on each 8-bit half against the parity bit stored with that half, and then drives inhibit lines so that the array writes the buffered word back. Parity for the write is generated fresh from the buffer.

Besides the sense pulses, three transfer paths can set buffer bits: the instruction address path, the I/O data path and the accumulator path. All of them are ORed per bit. A store cycle ignores the sensed data, so the word written comes only from the transfer paths. A test input can set one chosen buffer bit during the capture window, which gives a way to trip the parity stop on purpose. The parity stop is a sticky flag that names the failing half and stays set until it is cleared from outside.

Bit numbering: bit 0 is the most significant bit and sits at vector index 15. The left half is bits 0–7 (indices 15:8) and the right half is bits 8–15 (indices 7:0). On every 2-bit parity bus, index 1 belongs to the left half and index 0 to the right half.

Top module: `cmb_core_buffer`

## Requirements
- R1: A cycle starts only when `cyc_start` is high while `cyc_busy` is low. It then runs one read-strobe cycle (`mem_rd` high), SENSE_CYC capture cycles, one check cycle and WRITE_CYC write cycles (`mem_wr` high), which is 6 busy cycles with the defaults. `cyc_start` has no effect while busy.
- R2: The buffer is cleared at the end of the read-strobe cycle. During each capture cycle, `sense_word` bits set the matching buffer bits and `sense_par` bits set the captured parity bits.
- R3: During capture cycles only, each of `iar_pulse`, `io_pulse` and `acc_pulse` ORs its data word into the buffer. Outside capture cycles these inputs leave `sbr_q` unchanged.
- R4: When `cyc_store` is high at the start, sensed data and sensed parity are ignored and no parity check is made. The word written back is the OR of the transfer data.
- R5: On a fetch cycle (not a store), a half fails when its ones count plus its captured parity bit is even. A failure sets `pstop` one edge after the check cycle and sets the matching `pstop_half` bit (index 1 is left, index 0 is right).
- R6: `pstop` and `pstop_half` hold until `pstop_clr` is sampled high. If a new failure and `pstop_clr` fall on the same edge, the failure wins.
- R7: During write cycles `inhibit` is the bitwise inverse of the buffer and `mem_wr` is high. Outside write cycles `inhibit` and `inhibit_par` are zero. The stored word after the cycle equals the buffer.
- R8: The written parity is taken from the buffer at the check cycle. A half's bit is 1 when that half holds an even number of ones, and `inhibit_par` is its inverse.
- R9: `mem_addr` carries the 13-bit `cyc_addr` sampled at the start and holds it for the whole cycle, across the full range 0 to 8191.
- R10: With `inj_en` high during a capture cycle, the buffer bit numbered `inj_bit` is set. Bit n sits at vector index 15-n, so bit 10 is mask 0x0020.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | Start a memory cycle |
| cyc_store | input | 1 | 1: store cycle, 0: fetch cycle |
| cyc_addr | input | 13 | Word address for the cycle |
| cyc_busy | output | 1 | Cycle in progress |
| iar_pulse | input | 1 | Instruction address transfer strobe |
| iar_data | input | 16 | Instruction address transfer data |
| io_pulse | input | 1 | I/O transfer strobe |
| io_data | input | 16 | I/O transfer data |
| acc_pulse | input | 1 | Accumulator transfer strobe |
| acc_data | input | 16 | Accumulator transfer data |
| inj_en | input | 1 | Force a spurious set on one bit |
| inj_bit | input | 4 | Bit number to force (0 = MSB) |
| pstop_clr | input | 1 | Clear the parity stop |
| mem_addr | output | 13 | Address to the storage array |
| mem_rd | output | 1 | Destructive read strobe |
| sense_word | input | 16 | Sense pulses for the data bits |
| sense_par | input | 2 | Sense pulses for the parity bits |
| mem_wr | output | 1 | Write-back phase |
| inhibit | output | 16 | Inhibit per data bit |
| inhibit_par | output | 2 | Inhibit per parity bit |
| sbr_q | output | 16 | Buffer register contents |
| pstop | output | 1 | Parity stop flag |
| pstop_half | output | 2 | Failing halves (1 left, 0 right) |

## Verification
A wrong buffer bit appears on `sbr_q` on the edge after the faulty capture. Two cycles later it shows on `inhibit` as soon as the write phase opens, and it remains in the array afterwards under parity that looks consistent. A wrong captured parity bit can only be seen through `pstop` and `pstop_half`, which change exactly one edge after the check cycle. The reference model is therefore compared on every clock, so a fault is caught in the cycle where it first appears and not at the end of the memory cycle. A sequencer fault moves `mem_rd`, `mem_wr` or `cyc_busy` by whole cycles, and a per-clock comparison shows this at once.

// File: rtl/cmb_pkg.sv
// Package: shared phase encoding and strobe bundle for the core buffer block.
// Assumes a single clock domain; all strobes are one-cycle-per-phase levels.
package cmb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_READ  = 3'd1,
        PH_SENSE = 3'd2,
        PH_CHECK = 3'd3,
        PH_WRITE = 3'd4
    } cmb_phase_e;

    typedef struct packed {
        logic rd;
        logic sense;
        logic check;
        logic wr;
    } cmb_strobe_t;

endpackage

// File: rtl/cmb_seq.sv
// Module: memory cycle sequencer.
// Steps one read strobe, SENSE_CYC capture cycles, one check cycle and
// WRITE_CYC write cycles. Latches address and cycle kind at the start.
// Assumes SENSE_CYC and WRITE_CYC are at least 1.
module cmb_seq
    import cmb_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int SENSE_CYC = 2,
    parameter int WRITE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              store,
    input  logic [ADDR_W-1:0] addr,
    output cmb_strobe_t       stb,
    output logic [ADDR_W-1:0] addr_q,
    output logic              store_q,
    output logic              busy
);
    localparam int LONGEST = (SENSE_CYC > WRITE_CYC) ? SENSE_CYC : WRITE_CYC;
    localparam int CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;
    localparam logic [CNT_W-1:0] SENSE_LAST = CNT_W'(SENSE_CYC - 1);
    localparam logic [CNT_W-1:0] WRITE_LAST = CNT_W'(WRITE_CYC - 1);

    cmb_phase_e       phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             accept;

    assign accept = (phase_q == PH_IDLE) && start;

    // Next phase and in-phase counter.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) phase_d = PH_READ;
            end
            PH_READ: begin
                phase_d = PH_SENSE;
                cnt_d   = '0;
            end
            PH_SENSE: begin
                if (cnt_q == SENSE_LAST) begin
                    phase_d = PH_CHECK;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            PH_CHECK: begin
                phase_d = PH_WRITE;
                cnt_d   = '0;
            end
            PH_WRITE: begin
                if (cnt_q == WRITE_LAST) begin
                    phase_d = PH_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Phase register and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // Capture address and cycle kind when a cycle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            store_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= addr;
            store_q <= store;
        end
    end

    // Decode phase strobes.
    always_comb begin
        stb.rd    = (phase_q == PH_READ);
        stb.sense = (phase_q == PH_SENSE);
        stb.check = (phase_q == PH_CHECK);
        stb.wr    = (phase_q == PH_WRITE);
        busy      = (phase_q != PH_IDLE);
    end

endmodule

// File: rtl/cmb_sbr.sv
// Module: buffer register with ORed set sources.
// Each bit is set by any of: gated sense pulse, address transfer, I/O
// transfer, accumulator transfer or the test injection. Sets are taken only
// while 'take' is high; 'clr' empties the buffer. Bit n of the word
// numbering (n = 0 is the MSB) sits at index WORD_W-1-n.
module cmb_sbr #(
    parameter int WORD_W = 16,
    parameter int PAR_W  = 2,
    parameter int IDX_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic              gate_sense,
    input  logic [WORD_W-1:0] sense_word,
    input  logic [PAR_W-1:0]  sense_par,
    input  logic              iar_pulse,
    input  logic [WORD_W-1:0] iar_data,
    input  logic              io_pulse,
    input  logic [WORD_W-1:0] io_data,
    input  logic              acc_pulse,
    input  logic [WORD_W-1:0] acc_data,
    input  logic              inj_en,
    input  logic [IDX_W-1:0]  inj_bit,
    output logic [WORD_W-1:0] word_q,
    output logic [PAR_W-1:0]  par_q
);
    logic [WORD_W-1:0] set_vec;
    logic [PAR_W-1:0]  par_set;

    // Per-bit OR of every set source.
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        localparam logic [IDX_W-1:0] POS = IDX_W'(WORD_W - 1 - i);
        assign set_vec[i] = (gate_sense & sense_word[i])
                          | (iar_pulse  & iar_data[i])
                          | (io_pulse   & io_data[i])
                          | (acc_pulse  & acc_data[i])
                          | (inj_en     & (inj_bit == POS));
    end

    assign par_set = {PAR_W{gate_sense}} & sense_par;

    // Data buffer: clear, then accumulate sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (clr) begin
            word_q <= '0;
        end else if (take) begin
            word_q <= word_q | set_vec;
        end
    end

    // Captured parity bits: clear, then accumulate sensed parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= '0;
        end else if (clr) begin
            par_q <= '0;
        end else if (take) begin
            par_q <= par_q | par_set;
        end
    end

endmodule

// File: rtl/cmb_parity.sv
// Module: per-half odd parity check and generation with sticky stop flag.
// Half h covers word[h*HALF_W +: HALF_W]; parity index h belongs to it,
// so the highest index is the leftmost half. Assumes WORD_W divides by HALVES.
module cmb_parity #(
    parameter int WORD_W = 16,
    parameter int HALVES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              check_stb,
    input  logic              check_on,
    input  logic              clr_stop,
    input  logic [WORD_W-1:0] word,
    input  logic [HALVES-1:0] stored_par,
    output logic [HALVES-1:0] gen_par_q,
    output logic              stop_q,
    output logic [HALVES-1:0] bad_q
);
    localparam int HALF_W = WORD_W / HALVES;

    logic [HALVES-1:0] half_bad;
    logic [HALVES-1:0] fresh_par;
    logic              trip;

    // Per-half check against stored bit and fresh parity for write-back.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [HALF_W-1:0] slice;
        assign slice        = word[h*HALF_W +: HALF_W];
        assign half_bad[h]  = ~(^{slice, stored_par[h]});
        assign fresh_par[h] = ~(^slice);
    end

    assign trip = check_stb & check_on & (|half_bad);

    // Sticky stop flag: a new failure outranks the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            bad_q  <= '0;
        end else if (trip) begin
            stop_q <= 1'b1;
            bad_q  <= bad_q | half_bad;
        end else if (clr_stop) begin
            stop_q <= 1'b0;
            bad_q  <= '0;
        end
    end

    // Write parity is frozen from the buffer at the check cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_par_q <= '0;
        end else if (check_stb) begin
            gen_par_q <= fresh_par;
        end
    end

endmodule

// File: rtl/cmb_core_buffer.sv
// Module: core memory word buffer with split parity (top).
// Sequences destructive read, capture, parity check and write-back for one
// word. The storage array is external: it answers mem_rd with sense pulses
// one cycle later and writes the complement of the inhibits while mem_wr.
module cmb_core_buffer
    import cmb_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int HALVES    = 2,
    parameter int ADDR_W    = 13,
    parameter int SENSE_CYC = 2,
    parameter int WRITE_CYC = 2,
    parameter int IDX_W     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              cyc_store,
    input  logic [ADDR_W-1:0] cyc_addr,
    output logic              cyc_busy,
    input  logic              iar_pulse,
    input  logic [WORD_W-1:0] iar_data,
    input  logic              io_pulse,
    input  logic [WORD_W-1:0] io_data,
    input  logic              acc_pulse,
    input  logic [WORD_W-1:0] acc_data,
    input  logic              inj_en,
    input  logic [IDX_W-1:0]  inj_bit,
    input  logic              pstop_clr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [WORD_W-1:0] sense_word,
    input  logic [HALVES-1:0] sense_par,
    output logic              mem_wr,
    output logic [WORD_W-1:0] inhibit,
    output logic [HALVES-1:0] inhibit_par,
    output logic [WORD_W-1:0] sbr_q,
    output logic              pstop,
    output logic [HALVES-1:0] pstop_half
);
    cmb_strobe_t       stb;
    logic              store_q;
    logic [HALVES-1:0] cap_par;
    logic [HALVES-1:0] wr_par;

    cmb_seq #(
        .ADDR_W   (ADDR_W),
        .SENSE_CYC(SENSE_CYC),
        .WRITE_CYC(WRITE_CYC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cyc_start),
        .store  (cyc_store),
        .addr   (cyc_addr),
        .stb    (stb),
        .addr_q (mem_addr),
        .store_q(store_q),
        .busy   (cyc_busy)
    );

    cmb_sbr #(
        .WORD_W(WORD_W),
        .PAR_W (HALVES),
        .IDX_W (IDX_W)
    ) u_sbr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (stb.rd),
        .take      (stb.sense),
        .gate_sense(~store_q),
        .sense_word(sense_word),
        .sense_par (sense_par),
        .iar_pulse (iar_pulse),
        .iar_data  (iar_data),
        .io_pulse  (io_pulse),
        .io_data   (io_data),
        .acc_pulse (acc_pulse),
        .acc_data  (acc_data),
        .inj_en    (inj_en),
        .inj_bit   (inj_bit),
        .word_q    (sbr_q),
        .par_q     (cap_par)
    );

    cmb_parity #(
        .WORD_W(WORD_W),
        .HALVES(HALVES)
    ) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .check_stb (stb.check),
        .check_on  (~store_q),
        .clr_stop  (pstop_clr),
        .word      (sbr_q),
        .stored_par(cap_par),
        .gen_par_q (wr_par),
        .stop_q    (pstop),
        .bad_q     (pstop_half)
    );

    // Array strobes and inhibit drive, quiet outside the write phase.
    always_comb begin
        mem_rd      = stb.rd;
        mem_wr      = stb.wr;
        inhibit     = stb.wr ? ~sbr_q  : '0;
        inhibit_par = stb.wr ? ~wr_par : '0;
    end

endmodule

// File: rtl/cmb_core_buffer_chk.sv
// Module: protocol checker bound to the core buffer top.
// Observes ports only; all properties are disabled during reset.
module cmb_core_buffer_chk #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 13,
    parameter int PAR_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_busy,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] sbr_q,
    input logic              pstop,
    input logic              pstop_clr
);
    // R1: read strobe and write phase never overlap
    a_r1_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R1: read strobe lasts exactly one cycle
    a_r1_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R2: buffer is empty right after the read strobe
    a_r2_clear_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (sbr_q == '0));

    // R7: buffer does not move while it drives the inhibits
    a_r7_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> $stable(sbr_q));

    // R9: address held for the whole cycle
    a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_busy && $past(cyc_busy)) |-> $stable(mem_addr));

    // R6: stop flag holds unless cleared
    a_r6_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pstop && !pstop_clr) |=> pstop);

    // R5: stop flag rises only as the write phase opens
    a_r5_stop_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pstop) |-> mem_wr);

endmodule

bind cmb_core_buffer cmb_core_buffer_chk #(
    .WORD_W(WORD_W),
    .ADDR_W(ADDR_W),
    .PAR_W (HALVES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_busy (cyc_busy),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .sbr_q    (sbr_q),
    .pstop    (pstop),
    .pstop_clr(pstop_clr)
);

// File: tb/tb_cmb_core_buffer.sv
`timescale 1ns/1ps
module tb_cmb_core_buffer;
    localparam int SENSE_CYC = 2;
    localparam int WRITE_CYC = 2;
    localparam int BUSY_LEN  = 1 + SENSE_CYC + 1 + WRITE_CYC;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cyc_start, cyc_store;
    logic [12:0] cyc_addr;
    logic        cyc_busy;
    logic        iar_pulse, io_pulse, acc_pulse, inj_en, pstop_clr;
    logic [15:0] iar_data, io_data, acc_data;
    logic [3:0]  inj_bit;
    logic [12:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] sense_word;
    logic [1:0]  sense_par;
    logic [15:0] inhibit;
    logic [1:0]  inhibit_par;
    logic [15:0] sbr_q;
    logic        pstop;
    logic [1:0]  pstop_half;

    always #2.5 clk = ~clk;

    cmb_core_buffer dut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_store(cyc_store),
        .cyc_addr(cyc_addr), .cyc_busy(cyc_busy),
        .iar_pulse(iar_pulse), .iar_data(iar_data), .io_pulse(io_pulse), .io_data(io_data),
        .acc_pulse(acc_pulse), .acc_data(acc_data), .inj_en(inj_en), .inj_bit(inj_bit),
        .pstop_clr(pstop_clr), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .sense_word(sense_word), .sense_par(sense_par), .mem_wr(mem_wr),
        .inhibit(inhibit), .inhibit_par(inhibit_par), .sbr_q(sbr_q),
        .pstop(pstop), .pstop_half(pstop_half)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Good odd parity for a word: {left, right}
    function automatic logic [1:0] gp(input logic [15:0] w);
        gp[1] = ($countones(w[15:8]) % 2) == 0;
        gp[0] = ($countones(w[7:0]) % 2) == 0;
    endfunction

    // Behavioural storage array: {parity[1:0], data[15:0]}
    logic [17:0] mem [int];
    logic [17:0] mw;

    function automatic logic [17:0] rdm(input int a);
        return mem.exists(a) ? mem[a] : 18'h0;
    endfunction

    always @(posedge clk) begin
        sense_word <= '0;
        sense_par  <= '0;
        if (rst_n && mem_rd) begin
            mw = rdm(int'(mem_addr));
            sense_word <= mw[15:0];
            sense_par  <= mw[17:16];
            mem[int'(mem_addr)] = 18'h0;
        end
        if (rst_n && mem_wr) begin
            mw = rdm(int'(mem_addr));
            mem[int'(mem_addr)] = mw | {~inhibit_par, ~inhibit};
        end
    end

    // Reference model, cycle by cycle
    int          ph, cnt;
    logic [15:0] m_sbr, m_set;
    logic [1:0]  m_pb, m_wp, m_half, m_bad;
    logic        m_pstop, m_store, m_trip;
    logic [12:0] m_addr;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; cnt = 0; m_sbr = '0; m_pb = '0; m_wp = '0; m_half = '0;
            m_pstop = 0; m_store = 0; m_addr = '0;
        end else begin
            m_trip = 0;
            case (ph)
                0: if (cyc_start) begin ph = 1; m_addr = cyc_addr; m_store = cyc_store; end
                1: begin m_sbr = '0; m_pb = '0; ph = 2; cnt = 0; end
                2: begin
                    m_set = '0;
                    if (!m_store) m_set = m_set | sense_word;
                    if (iar_pulse) m_set = m_set | iar_data;
                    if (io_pulse)  m_set = m_set | io_data;
                    if (acc_pulse) m_set = m_set | acc_data;
                    if (inj_en)    m_set = m_set | (16'h8000 >> inj_bit);
                    m_sbr = m_sbr | m_set;
                    if (!m_store) m_pb = m_pb | sense_par;
                    cnt++;
                    if (cnt == SENSE_CYC) ph = 3;
                end
                3: begin
                    m_bad[1] = ($countones({m_sbr[15:8], m_pb[1]}) % 2) == 0;
                    m_bad[0] = ($countones({m_sbr[7:0],  m_pb[0]}) % 2) == 0;
                    if (!m_store && (m_bad != 2'b00)) begin
                        m_trip = 1; m_pstop = 1; m_half = m_half | m_bad;
                    end
                    m_wp = gp(m_sbr);
                    ph = 4; cnt = 0;
                end
                default: begin cnt++; if (cnt == WRITE_CYC) ph = 0; end
            endcase
            if (!m_trip && pstop_clr) begin m_pstop = 0; m_half = '0; end
        end
    end

    // Per-clock comparison, away from the active edge
    logic [15:0] e_inh;
    logic [1:0]  e_ipar;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            e_inh  = (ph == 4) ? ~m_sbr : 16'h0;
            e_ipar = (ph == 4) ? ~m_wp  : 2'h0;
            chk("R1", "cyc_busy", cyc_busy, ph != 0);
            chk("R1", "mem_rd", mem_rd, ph == 1);
            chk("R7", "mem_wr", mem_wr, ph == 4);
            chk("R2", "sbr_q", sbr_q, m_sbr);
            chk("R7", "inhibit", inhibit, e_inh);
            chk("R8", "inhibit_par", inhibit_par, e_ipar);
            chk("R5", "pstop", pstop, m_pstop);
            chk("R6", "pstop_half", pstop_half, m_half);
            chk("R9", "mem_addr", mem_addr, m_addr);
        end
    end

    task automatic idle_inputs();
        cyc_start = 0; cyc_store = 0; cyc_addr = '0;
        iar_pulse = 0; iar_data = '0; io_pulse = 0; io_data = '0;
        acc_pulse = 0; acc_data = '0; inj_en = 0; inj_bit = '0;
    endtask

    // Runs one cycle from a negedge; returns at the first idle negedge
    task automatic run_cycle(input logic [12:0] a, input logic st,
                             input logic [15:0] iard, input logic [15:0] iod,
                             input logic [15:0] accd, input logic ie,
                             input logic [3:0] ib, input bit restart,
                             output int busy_n);
        cyc_addr = a; cyc_store = st;
        iar_pulse = (iard != 0); iar_data = iard;
        io_pulse  = (iod  != 0); io_data  = iod;
        acc_pulse = (accd != 0); acc_data = accd;
        inj_en = ie; inj_bit = ib;
        cyc_start = 1;
        @(negedge clk);
        cyc_start = 0;
        busy_n = 0;
        while (cyc_busy && busy_n < 50) begin
            busy_n++;
            if (restart && busy_n == 2) begin
                cyc_start = 1; cyc_addr = a ^ 13'h1555;
            end else begin
                cyc_start = 0;
            end
            @(negedge clk);
        end
        idle_inputs();
    endtask

    task automatic pulse_clear();
        pstop_clr = 1;
        @(negedge clk);
        pstop_clr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] held;
        idle_inputs();
        pstop_clr = 0;
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state
        chk("R1", "reset busy", cyc_busy, 0);
        chk("R5", "reset pstop", pstop, 0);
        chk("R2", "reset sbr", sbr_q, 0);

        // Clean fetch with restore
        mem[32'h258] = {gp(16'hC200), 16'hC200};
        run_cycle(13'h258, 0, 0, 0, 0, 0, 0, 0, n);
        chk("R1", "busy length", n, BUSY_LEN);
        chk("R2", "fetch word", sbr_q, 16'hC200);
        chk("R7", "restored word", rdm(32'h258), {2'b01, 16'hC200});
        chk("R5", "clean fetch no stop", pstop, 0);

        // Spurious bit 10 on the right half
        run_cycle(13'h258, 0, 0, 0, 0, 1, 4'd10, 0, n);
        chk("R10", "inject bit 10", sbr_q, 16'hC220);
        chk("R5", "stop on right", pstop, 1);
        chk("R5", "right half flagged", pstop_half, 2'b01);
        chk("R8", "regenerated parity", rdm(32'h258), {2'b00, 16'hC220});

        // Stop stays through a clean cycle, then clears
        mem[32'h100] = {gp(16'h0F0F), 16'h0F0F};
        run_cycle(13'h100, 0, 0, 0, 0, 0, 0, 0, n);
        chk("R6", "stop sticky", pstop, 1);
        pulse_clear();
        chk("R6", "stop cleared", pstop, 0);
        chk("R6", "halves cleared", pstop_half, 2'b00);

        // Store at top address: sense ignored, bad old parity irrelevant
        mem[32'h1FFF] = {2'b11, 16'hFFFF};
        run_cycle(13'h1FFF, 1, 0, 16'h0001, 16'h1234, 0, 0, 0, n);
        chk("R4", "store buffer", sbr_q, 16'h1235);
        chk("R4", "store no stop", pstop, 0);
        chk("R9", "top address written", rdm(32'h1FFF), {gp(16'h1235), 16'h1235});

        // Address path ORs with sensed word on a fetch
        mem[32'h040] = {gp(16'h00F0), 16'h00F0};
        run_cycle(13'h040, 0, 16'h0F00, 0, 0, 0, 0, 0, n);
        chk("R3", "iar OR sense", sbr_q, 16'h0FF0);
        pulse_clear();

        // Left parity bit wrong in storage
        mem[32'h0AA] = {2'b10, 16'h8001};
        run_cycle(13'h0AA, 0, 0, 0, 0, 0, 0, 0, n);
        chk("R5", "stop on left", pstop, 1);
        chk("R5", "left half flagged", pstop_half, 2'b10);
        pulse_clear();

        // Failure beats a clear held through the whole cycle
        mem[32'h0AB] = {2'b10, 16'h8001};
        pstop_clr = 1;
        run_cycle(13'h0AB, 0, 0, 0, 0, 0, 0, 0, n);
        pstop_clr = 0;
        chk("R6", "cleared after set-wins edge", pstop, 0);

        // Transfer pulses while idle are ignored
        held = sbr_q;
        iar_pulse = 1; iar_data = 16'hFFFF; acc_pulse = 1; acc_data = 16'hAAAA;
        inj_en = 1; inj_bit = 4'd3;
        repeat (3) @(negedge clk);
        chk("R3", "idle pulses ignored", sbr_q, held);
        idle_inputs();
        @(negedge clk);

        // Start while busy is ignored
        mem[32'h333] = {gp(16'h5A5A), 16'h5A5A};
        run_cycle(13'h333, 0, 0, 0, 0, 0, 0, 1, n);
        chk("R1", "restart ignored length", n, BUSY_LEN);
        chk("R2", "restart word", sbr_q, 16'h5A5A);
        @(negedge clk);
        chk("R1", "no second cycle", cyc_busy, 0);

        // Assorted clean fetches
        for (int k = 0; k < 8; k++) begin
            logic [15:0] w;
            logic [12:0] a;
            w = 16'($urandom());
            a = 13'(16'h0800 + k * 37);
            mem[int'(a)] = {gp(w), w};
            run_cycle(a, 0, 0, 0, 0, 0, 0, 0, n);
            chk("R2", "random fetch", sbr_q, w);
            chk("R7", "random restore", rdm(int'(a)), {gp(w), w});
            chk("R5", "random no stop", pstop, 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule